// File: doc/BRIEF.md
# Shadowed Compare PWM Waveform Generator

This block produces one pulse-width-modulated output from a free-running time-base counter. The counter has two modes. In the first it climbs to a programmable period value and then wraps to zero. In the second it climbs to the period value and then falls back to zero. Four counter events can each drive the output: reaching zero, reaching the period value, a compare match while rising, and a compare match while falling. Each event has its own two-bit action field.

The compare value is double-buffered. Software writes a shadow copy. The active copy takes the shadow value only at one counter event per period: either at zero or at the period value, chosen by a control bit. Because the block tells rising matches apart from falling matches, it can produce centred (symmetric) and edge-aligned (asymmetric) waveforms. Fixed event priorities give clean 0% and 100% duty limits.

Configuration uses a simple write port with a two-bit address:

| Address | Register | Contents |
|---|---|---|
| 0 | period | period value |
| 1 | shadow compare | compare value waiting to be loaded |
| 2 | control | bit 0: mode (0 up-count, 1 up-down); bit 1: load at period (1) or at zero (0) |
| 3 | actions | bits [1:0] zero event, [3:2] period event, [5:4] rising match, [7:6] falling match |

Top module: `shadow_pwm_gen`

## Requirements
- R1: After reset the output is low, the counter is 0 and counting up, and both the active and the shadow compare values are 0. With zero-set and rising-match-clear actions and no compare write, the output stays low.
- R2: When control bit 0 is 0 (up-count mode), the counter steps 0,1,...,P and then returns to 0. One PWM period is P+1 clocks.
- R3: When control bit 0 is 1 (up-down mode), the counter steps 0,1,...,P,P-1,...,1 and repeats. One PWM period is 2P clocks, and the direction flips at each end point.
- R4: Each 2-bit action field is coded as follows: 00 leaves the output unchanged, 01 drives it low, 10 drives it high, and 11 inverts it. The action takes effect on the clock after the event.
- R5: A write to the shadow compare (address 1) never changes the active compare value except at the load event. With control bit 1 = 0 the load event is counter = 0; with bit 1 = 1 it is counter = period.
- R6: Symmetric up-down PWM uses actions 0x60 (rising match sets, falling match clears). Each period the output is high for 2(P-C) clocks when 1 ≤ C ≤ P-1. It is high for 0 clocks when C = 0 and for 2P clocks when C = P.
- R7: Asymmetric up-count PWM uses actions 0x12 (zero sets, rising match clears). The output is high for C clocks per period for every C from 0 to P+1, which covers 0% to 100% duty.
- R8: Asymmetric up-down PWM uses actions 0x24 (period clears, rising match sets). The output is high for P-C clocks per period for C from 0 to P, which covers 50% down to 0% duty.
- R9: When several events fall in one clock, only events whose action is not 00 compete, and one action is applied. In up-count mode the order is compare match, then period, then zero. In up-down mode the order is period, then zero, then compare. At an up-down end point a match counts as both rising and falling. If both match actions are non-zero, the direction in which the counter arrived at that end point decides between them.
- R10: Writes to period (address 0), control and actions take effect from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | CNT_W | Write data |
| pwm_out | output | 1 | PWM waveform |

## Verification
Two functions can fall in the same clock. A compare match can coincide with the zero or period event, and a shadow load can coincide with the compare decision it feeds. The bench provokes the first collision by programming compare values of 0, P and P+1 in each mode. Each result is judged by the measured high time over several whole periods, which must equal the 0% or 100% limit the priority rules predict. The load-timing collision is provoked by writing a new shadow value in the middle of a centred pulse. The bench then checks that this pulse is bounded by the old value on one side and by the new value on the other side only when loading at period is selected.

// File: rtl/shadow_pwm_gen.sv
module shadow_pwm_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  output logic             pwm_out
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [1:0] AD_PRD = 2'd0, AD_CMP = 2'd1, AD_CTL = 2'd2, AD_ACT = 2'd3;
  localparam logic [1:0] AC_NONE = 2'b00, AC_CLR = 2'b01, AC_SET = 2'b10, AC_TOG = 2'b11;

  logic [CNT_W-1:0] prd_q, cmp_sh_q, cmp_act_q, cnt_q;
  logic             ud_q, ld_prd_q, dir_up_q, pwm_q;
  logic [7:0]       act_q;

  wire [1:0] act_zro = act_q[1:0];
  wire [1:0] act_prd = act_q[3:2];
  wire [1:0] act_cau = act_q[5:4];
  wire [1:0] act_cad = act_q[7:6];

  wire at_zero = (cnt_q == '0);
  wire at_prd  = (cnt_q == prd_q);
  wire cmp_eq  = (cnt_q == cmp_act_q);
  wire at_end  = ud_q && (at_zero || at_prd);
  wire up_hit  = cmp_eq && (dir_up_q || at_end);
  wire dn_hit  = cmp_eq && (!dir_up_q || at_end);
  wire ld_ev   = ld_prd_q ? at_prd : at_zero;
  wire any_ev  = at_zero || at_prd || cmp_eq;

  logic [1:0] cmp_sel, end_sel, act_sel;

  always_comb begin
    cmp_sel = AC_NONE;
    if (up_hit && act_cau != AC_NONE && dn_hit && act_cad != AC_NONE)
      cmp_sel = dir_up_q ? act_cau : act_cad;
    else if (up_hit && act_cau != AC_NONE)
      cmp_sel = act_cau;
    else if (dn_hit)
      cmp_sel = act_cad;
  end

  always_comb begin
    end_sel = AC_NONE;
    if (at_prd && act_prd != AC_NONE)
      end_sel = act_prd;
    else if (at_zero)
      end_sel = act_zro;
  end

  assign act_sel = ud_q ? ((end_sel != AC_NONE) ? end_sel : cmp_sel)
                        : ((cmp_sel != AC_NONE) ? cmp_sel : end_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      dir_up_q <= 1'b1;
    end else if (!ud_q) begin
      dir_up_q <= 1'b1;
      cnt_q    <= (cnt_q >= prd_q) ? '0 : cnt_q + ONE;
    end else if (dir_up_q) begin
      if (cnt_q >= prd_q) begin
        dir_up_q <= 1'b0;
        cnt_q    <= at_zero ? '0 : cnt_q - ONE;
      end else begin
        cnt_q    <= cnt_q + ONE;
      end
    end else begin
      if (at_zero) begin
        dir_up_q <= 1'b1;
        cnt_q    <= (prd_q == '0) ? '0 : ONE;
      end else begin
        cnt_q    <= cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_q    <= '0;
      cmp_sh_q <= '0;
      ud_q     <= 1'b0;
      ld_prd_q <= 1'b0;
      act_q    <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        AD_PRD:  prd_q    <= cfg_wdata;
        AD_CMP:  cmp_sh_q <= cfg_wdata;
        AD_CTL:  {ld_prd_q, ud_q} <= cfg_wdata[1:0];
        default: act_q    <= cfg_wdata[7:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     cmp_act_q <= '0;
    else if (ld_ev) cmp_act_q <= cmp_sh_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pwm_q <= 1'b0;
    else begin
      case (act_sel)
        AC_CLR:  pwm_q <= 1'b0;
        AC_SET:  pwm_q <= 1'b1;
        AC_TOG:  pwm_q <= ~pwm_q;
        default: pwm_q <= pwm_q;
      endcase
    end
  end

  assign pwm_out = pwm_q;
endmodule

// File: rtl/shadow_pwm_gen_chk.sv
module shadow_pwm_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ud,
  input logic             dir_up,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] prd,
  input logic [CNT_W-1:0] cmp_act,
  input logic             ld_ev,
  input logic             any_ev,
  input logic             pwm
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  a_r5_load_only_at_event: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act != $past(cmp_act)) |-> $past(ld_ev));

  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!ud && cnt >= prd) |=> (cnt == '0));

  a_r3_turn_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (ud && dir_up && cnt >= prd && prd != '0) |=> !dir_up);

  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ud && cnt != '0 && cnt < prd) |=>
      (cnt == $past(cnt) + ONE || cnt == $past(cnt) - ONE));

  a_r4_change_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm != $past(pwm)) |-> $past(any_ev));
endmodule

bind shadow_pwm_gen shadow_pwm_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ud(ud_q), .dir_up(dir_up_q), .cnt(cnt_q),
  .prd(prd_q), .cmp_act(cmp_act_q), .ld_ev(ld_ev), .any_ev(any_ev), .pwm(pwm_q)
);

// File: tb/test_shadow_pwm_gen.sv
module test_shadow_pwm_gen;
  localparam int W = 16;
  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [W-1:0] cfg_wdata = '0;
  logic pwm_out;
  int n_run = 0, n_fail = 0;

  shadow_pwm_gen #(.CNT_W(W)) i_shadow_pwm_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pwm_out(pwm_out));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = W'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input bit ud, input bit ldp, input int p, input int c, input int acts);
    do_reset();
    wr(2'd0, p); wr(2'd2, {30'd0, ldp, ud}); wr(2'd3, acts); wr(2'd1, c);
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  task automatic duty_case(input string tag, input bit ud, input int p, input int c,
                           input int acts, input int exp_hi);
    int len, hi;
    setup(ud, 1'b1, p, c, acts);
    len = ud ? 2 * p : p + 1;
    repeat (3 * len + 4) @(negedge clk);
    count_high(4 * len, hi);
    check(hi == 4 * exp_hi, tag, hi, 4 * exp_hi);
  endtask

  task automatic wait_rise();
    logic prev;
    int guard = 0;
    prev = pwm_out;
    @(negedge clk);
    while (!(pwm_out && !prev) && guard < 2000) begin
      prev = pwm_out; guard++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_len(output int n);
    wait_rise();
    n = 0;
    while (pwm_out && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_with_write(input int newc, output int first, output int second);
    wait_rise();
    cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = W'(newc);
    first = 1;
    @(negedge clk);
    cfg_we = 1'b0;
    while (pwm_out && first < 2000) begin
      first++;
      @(negedge clk);
    end
    pulse_len(second);
  endtask

  task automatic t_reset();
    int hi;
    do_reset();
    check(pwm_out == 1'b0, "R1 output low after reset", int'(pwm_out), 0);
    wr(2'd0, 9); wr(2'd3, 'h12);
    count_high(40, hi);
    check(hi == 0, "R1 compare defaults to 0 (0% duty)", hi, 0);
  endtask

  task automatic t_up_asym();
    duty_case("R7 up asym C=0",   1'b0, 9, 0,  'h12, 0);
    duty_case("R7 up asym C=4",   1'b0, 9, 4,  'h12, 4);
    duty_case("R7 up asym C=P",   1'b0, 9, 9,  'h12, 9);
    duty_case("R7 up asym C=P+1", 1'b0, 9, 10, 'h12, 10);
    duty_case("R2 up period 7 clocks", 1'b0, 6, 0, 'h06, 6);
  endtask

  task automatic t_symmetric();
    duty_case("R6 sym C=0", 1'b1, 8, 0, 'h60, 0);
    duty_case("R6 sym C=1", 1'b1, 8, 1, 'h60, 14);
    duty_case("R6 sym C=3", 1'b1, 8, 3, 'h60, 10);
    duty_case("R6 sym C=P", 1'b1, 8, 8, 'h60, 16);
  endtask

  task automatic t_ud_asym();
    duty_case("R8 ud asym C=0", 1'b1, 8, 0, 'h24, 8);
    duty_case("R8 ud asym C=5", 1'b1, 8, 5, 'h24, 3);
    duty_case("R9 ud asym C=P period outranks", 1'b1, 8, 8, 'h24, 0);
  endtask

  task automatic t_actions();
    int n, hi;
    setup(1'b0, 1'b1, 5, 0, 'h03);
    pulse_len(n);
    check(n == 6, "R4 toggle on zero gives P+1 pulse", n, 6);
    wr(2'd0, 3);
    repeat (10) @(negedge clk);
    pulse_len(n);
    check(n == 4, "R10 period write takes effect", n, 4);
    setup(1'b1, 1'b1, 8, 8, 'h60);
    repeat (40) @(negedge clk);
    wr(2'd3, 'h00);
    count_high(40, hi);
    check(hi == 40, "R4 no-action holds high level", hi, 40);
    wr(2'd3, 'h01);
    count_high(40, hi);
    check(hi <= 16, "R4 clear on zero drives low", hi, 16);
  endtask

  task automatic t_shadow();
    int a, b;
    setup(1'b0, 1'b1, 9, 3, 'h12);
    repeat (30) @(negedge clk);
    pulse_with_write(7, a, b);
    check(a == 3, "R5 shadow write holds current pulse", a, 3);
    check(b == 7, "R5 new compare used after load", b, 7);
    setup(1'b1, 1'b1, 10, 6, 'h60);
    repeat (60) @(negedge clk);
    pulse_with_write(2, a, b);
    check(a == 12, "R5 load at period splits centred pulse", a, 12);
    check(b == 16, "R5 load at period next pulse", b, 16);
    setup(1'b1, 1'b0, 10, 6, 'h60);
    repeat (60) @(negedge clk);
    pulse_with_write(2, a, b);
    check(a == 8, "R5 load at zero keeps pulse whole", a, 8);
    check(b == 16, "R3 R5 load at zero next pulse", b, 16);
  endtask

  initial begin
    t_reset();
    t_up_asym();
    t_symmetric();
    t_ud_asym();
    t_actions();
    t_shadow();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule